// File: doc/BRIEF.md
# FM Synthesizer Low-Frequency Oscillator

A single global low-frequency oscillator shared by all six channels of an FM sound generator. Software programs it through one control register that carries an enable bit and a 3-bit rate select. The sound engine pulses a per-sample tick once per output sample, after that sample has been computed. The oscillator then moves one step through a 128-position phase at the selected rate. It drives two modulation values. The first is a triangle amplitude-modulation step. The second is a coarser phase-modulation index that moves at a quarter of the amplitude rate.

Turning the oscillator on from the off state restarts it from zero. Writing the enable again while it runs changes only the rate. Turning it off freezes both outputs at their last values, so the channels keep applying that fixed modulation. Scaling the outputs by channel sensitivity and looking up phase offsets are done elsewhere.

Top module: `fm_lfo`

## Requirements
- R1: The phase has 128 positions and goes from 127 back to 0. After 128 steps from a restart, both outputs read 0 again.
- R2: am_o is a triangle of the phase p. It is 2*p for p < 64 and 254 - 2*p for p >= 64. It is always even and never above 126.
- R3: pm_o equals the phase divided by 4, rounded down.
- R4: Rate select 7, 6, 5, 4, 3, 2, 1 and 0 hold each phase position for 5, 8, 44, 62, 67, 71, 77 and 108 ticks respectively.
- R5: Only a write strobe with address 0x22 changes the control. Data bit 3 is the enable and data bits 2:0 are the rate select. A write to any other address has no effect on the outputs.
- R6: A write that sets the enable while the oscillator is off clears the phase and the tick counter. The outputs read 0 on the next cycle.
- R7: A write that sets the enable while the oscillator is already running updates only the rate. The phase and the outputs continue without a restart.
- R8: While the oscillator is off, ticks do not advance it and am_o and pm_o keep their values.
- R9: After reset the oscillator is off with rate select 0, and am_o and pm_o are 0.
- R10: The outputs change only in the cycle after a tick that completes a hold interval, or after a restarting write.
- R11: A rate change made while running applies from the next hold interval. The count already in progress is neither cleared nor shortened.
- R12: When a control write and a tick arrive in the same cycle, a restart or a disable takes priority over the tick. A rate-only write lets the tick count under the old interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | One-cycle pulse per output sample |
| am_o | output | 7 | Amplitude-modulation step |
| pm_o | output | 5 | Phase-modulation index |

## Verification
The bench uses the default parameters: a 7-bit phase, 8-bit address and data, and control address 0x22. At the fastest rate of 5 ticks per position, a full 128-position wrap takes only 640 ticks. Every one of the eight hold lengths can therefore be measured exactly, and the triangle can be followed through its peak and back to zero. Random traffic uses mostly the two fastest rates. It mixes in restarts, disables, rate-only writes, writes to foreign addresses and writes that coincide with ticks.

// File: rtl/fm_lfo_pkg.sv
package fm_lfo_pkg;
  localparam int unsigned PHASE_W = 7;
  localparam int unsigned AM_W    = PHASE_W;
  localparam int unsigned PM_W    = PHASE_W - 2;
  localparam int unsigned HOLD_W  = 7;
  localparam int unsigned RATE_W  = 3;

  localparam logic [AM_W-1:0] AM_MAX = {{(AM_W-1){1'b1}}, 1'b0};

  function automatic logic [HOLD_W-1:0] hold_len(input logic [RATE_W-1:0] r);
    case (r)
      3'd0:    return HOLD_W'(108);
      3'd1:    return HOLD_W'(77);
      3'd2:    return HOLD_W'(71);
      3'd3:    return HOLD_W'(67);
      3'd4:    return HOLD_W'(62);
      3'd5:    return HOLD_W'(44);
      3'd6:    return HOLD_W'(8);
      default: return HOLD_W'(5);
    endcase
  endfunction

  function automatic logic [AM_W-1:0] tri_am(input logic [PHASE_W-1:0] p);
    logic [AM_W-1:0] up;
    up = {p[PHASE_W-2:0], 1'b0};
    return p[PHASE_W-1] ? (AM_MAX - up) : up;
  endfunction
endpackage

// File: rtl/fm_lfo_regs.sv
module fm_lfo_regs
  import fm_lfo_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h22,
  parameter int unsigned EN_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [RATE_W-1:0] rate_o,
  output logic [RATE_W-1:0] new_rate_o,
  output logic              restart_o,
  output logic              run_o
);
  logic en_q, hit, want_en;

  assign hit        = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign want_en    = wr_data_i[EN_BIT];
  assign new_rate_o = wr_data_i[RATE_W-1:0];
  assign restart_o  = hit && want_en && !en_q;
  // disabling write in this cycle blocks the tick
  assign run_o      = en_q && !(hit && !want_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      rate_o <= '0;
    end else if (hit) begin
      en_q   <= want_en;
      rate_o <= new_rate_o;
    end
  end
endmodule

// File: rtl/fm_lfo_timer.sv
module fm_lfo_timer
  import fm_lfo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [RATE_W-1:0] new_rate_i,
  output logic              step_o
);
  logic [HOLD_W-1:0] cnt_q, cur_hold_q;
  logic              last;

  assign last   = (cnt_q == cur_hold_q - HOLD_W'(1));
  assign step_o = tick_i && run_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cur_hold_q <= hold_len('0);
    end else if (restart_i) begin
      cnt_q      <= '0;
      cur_hold_q <= hold_len(new_rate_i);
    end else if (tick_i && run_i) begin
      if (last) begin
        cnt_q      <= '0;
        cur_hold_q <= hold_len(rate_i);   // rate applies from the next interval
      end else begin
        cnt_q <= cnt_q + HOLD_W'(1);
      end
    end
  end
endmodule

// File: rtl/fm_lfo_wave.sv
module fm_lfo_wave
  import fm_lfo_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            step_i,
  output logic [AM_W-1:0] am_o,
  output logic [PM_W-1:0] pm_o
);
  logic [PHASE_W-1:0] phase_q, phase_nxt;

  assign phase_nxt = phase_q + PHASE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      am_o    <= '0;
      pm_o    <= '0;
    end else if (restart_i) begin
      phase_q <= '0;
      am_o    <= '0;
      pm_o    <= '0;
    end else if (step_i) begin
      phase_q <= phase_nxt;
      am_o    <= tri_am(phase_nxt);
      pm_o    <= phase_nxt[PHASE_W-1:2];
    end
  end
endmodule

// File: rtl/fm_lfo.sv
module fm_lfo
  import fm_lfo_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h22,
  parameter int unsigned EN_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic [AM_W-1:0]   am_o,
  output logic [PM_W-1:0]   pm_o
);
  logic [RATE_W-1:0] rate, new_rate;
  logic              restart, run, step;

  fm_lfo_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rate_o(rate), .new_rate_o(new_rate),
    .restart_o(restart), .run_o(run)
  );

  fm_lfo_timer u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(run),
    .restart_i(restart), .rate_i(rate), .new_rate_i(new_rate), .step_o(step)
  );

  fm_lfo_wave u_wave (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .step_i(step),
    .am_o(am_o), .pm_o(pm_o)
  );
endmodule

// File: rtl/fm_lfo_chk.sv
module fm_lfo_chk
  import fm_lfo_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h22,
  parameter int unsigned EN_BIT = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tick_i,
  input logic [AM_W-1:0]   am_o,
  input logic [PM_W-1:0]   pm_o
);
  logic hit, off_q;
  assign hit = wr_en_i && (wr_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  off_q <= 1'b1;
    else if (hit) off_q <= !wr_data_i[EN_BIT];
  end

  AST_AM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (am_o <= AM_MAX) && !am_o[0]); // R2

  AST_AM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hit) |=> (am_o == $past(am_o) || am_o == $past(am_o) + AM_W'(2)
                          || am_o == $past(am_o) - AM_W'(2))); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_data_i[EN_BIT] && off_q) |=> (am_o == '0 && pm_o == '0)); // R6

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q && !hit) |=> ($stable(am_o) && $stable(pm_o))); // R8

  AST_NO_TICK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !hit) |=> ($stable(am_o) && $stable(pm_o))); // R10
endmodule

bind fm_lfo fm_lfo_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .tick_i(tick_i), .am_o(am_o), .pm_o(pm_o)
);

// File: tb/fm_lfo_tb.sv
module fm_lfo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [6:0] am;
  logic [4:0] pm;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit       m_en = 0;
  int       m_rate = 0, m_cnt = 0, m_hold = 108, m_phase = 0;

  always #5 clk = ~clk;

  fm_lfo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .am_o(am), .pm_o(pm)
  );

  function automatic int h_of(input int r);
    int t[8] = '{108, 77, 71, 67, 62, 44, 8, 5};
    return t[r];
  endfunction

  function automatic int exp_am(input int p);
    return (p < 64) ? 2 * p : 254 - 2 * p;
  endfunction

  task automatic model(input bit tk, input bit wr, input logic [7:0] a, input logic [7:0] d);
    bit hit;
    int old_rate;
    hit = wr && (a == 8'h22);
    old_rate = m_rate;
    if (hit && d[3] && !m_en) begin
      m_en = 1; m_rate = d[2:0]; m_phase = 0; m_cnt = 0; m_hold = h_of(d[2:0]);
    end else if (hit && !d[3]) begin
      m_en = 0; m_rate = d[2:0];
    end else begin
      if (hit) m_rate = d[2:0];
      if (m_en && tk) begin
        if (m_cnt == m_hold - 1) begin
          m_cnt = 0; m_hold = h_of(old_rate); m_phase = (m_phase + 1) % 128;
        end else m_cnt++;
      end
    end
  endtask

  task automatic chk(input string req);
    int ea, ep;
    ea = exp_am(m_phase); ep = m_phase / 4;
    n_chk++;
    if (am !== 7'(ea) || pm !== 5'(ep)) begin
      n_fail++;
      $display("FAIL %s: am=%0d pm=%0d expected am=%0d pm=%0d", req, am, pm, ea, ep);
    end
  endtask

  // called at negedge; returns at following negedge with inputs idle
  task automatic cyc(input bit tk, input bit wr, input logic [7:0] a, input logic [7:0] d);
    tick = tk; wr_en = wr; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(tk, wr, a, d);
    @(negedge clk);
    tick = 0; wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h00, 8'h00);
  endtask

  task automatic ctrl(input logic [7:0] d);
    cyc(0, 1, 8'h22, d);
  endtask

  initial begin
    int rv;
    rv = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    chk("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    ticks(200);
    chk("R8 off after reset");

    // R4: every hold length, measured from a restart
    for (int r = 0; r < 8; r++) begin
      ctrl(8'h00);
      ctrl(8'h08 | 8'(r));
      chk("R6 restart zero");
      ticks(h_of(r) - 1);
      chk("R4 before hold end");
      if (am !== 7'd0) $display("note rate %0d", r);
      ticks(1);
      chk("R4 after hold end");
      if (am !== 7'd2) begin n_fail++; $display("FAIL R4: rate %0d am=%0d expected 2", r, am); end
      n_chk++;
    end

    // R1/R2/R3: full wrap at fastest rate
    ctrl(8'h00); ctrl(8'h0F);
    for (int s = 1; s <= 128; s++) begin
      ticks(5);
      chk((s % 4 == 0) ? "R3 pm" : "R2 am");
    end
    chk("R1 wrap");
    if (am !== 7'd0 || pm !== 5'd0) begin n_fail++; $display("FAIL R1: am=%0d pm=%0d expected 0 0", am, pm); end
    n_chk++;

    // R7: re-enable while running does not restart
    ticks(5 * 40);
    ctrl(8'h0F);
    chk("R7 no restart");
    ticks(5);
    chk("R7 continues");

    // R5: foreign addresses ignored
    cyc(0, 1, 8'h23, 8'h00);
    cyc(0, 1, 8'h02, 8'h00);
    chk("R5 other address");
    ticks(5);
    chk("R5 still running");

    // R8: disable holds
    ctrl(8'h07);
    ticks(300);
    chk("R8 held");
    ctrl(8'h0F);
    chk("R6 restart after off");

    // R11: rate change mid-interval
    ticks(2);
    ctrl(8'h0E);
    ticks(3);
    chk("R11 old interval completes");
    ticks(7);
    chk("R11 new interval not done");
    ticks(1);
    chk("R11 new interval done");

    // R12: disable coinciding with expiring tick
    ctrl(8'h00); ctrl(8'h0F);
    ticks(4);
    cyc(1, 1, 8'h22, 8'h07);
    chk("R12 disable wins");
    // rate write with expiring tick: tick counts
    ctrl(8'h0F);
    ticks(4);
    cyc(1, 1, 8'h22, 8'h0E);
    chk("R12 rate write with tick");
    // restart with tick
    ctrl(8'h00);
    cyc(1, 1, 8'h22, 8'h0F);
    chk("R12 restart wins");

    // random traffic
    for (int i = 0; i < 20000; i++) begin
      bit tk, wr;
      logic [7:0] a, d;
      tk = ($urandom % 10) < 7;
      wr = ($urandom % 100) < 3;
      a  = (($urandom % 5) != 0) ? 8'h22 : 8'($urandom);
      d  = 8'($urandom);
      d[3] = ($urandom % 5) != 0;
      if (($urandom % 4) != 0) d[2:1] = 2'b11;
      cyc(tk, wr, a, d);
      chk("R10 R2 R3 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule